// File: doc/BRIEF.md
# Low-Order Concatenation Overhead Bit Decoder

This block serves one member of a low-order virtually concatenated group. Once per 500 µs low-order multiframe, the upstream path-overhead logic gives it two bits on a single-cycle strobe. The first is the extended-label bit, which carries a fixed alignment pattern. The second is the concatenation bit, which carries the member's multiframe count and sequence number serially.

The decoder first searches the label-bit stream for the alignment pattern. When it finds the pattern, it fixes the phase of a 32-slot superframe lasting 16 ms. It confirms that phase, or loses it, with a small hunt / trial / locked / coast state machine. While locked, it uses the superframe phase to pick the count bits and the sequence bits out of the concatenation stream. It latches each field once the field is complete. It also flags any superframe whose count does not follow the previous one.

Downstream, the deskew logic uses the count to align members. The reassembly order comes from the sequence number.

Top module: `lovc_decoder`

## Requirements
- R1: Internal state and all outputs change only on the clock edge where `slot_valid` is high. Cycles without a strobe leave every output unchanged.
- R2: While hunting, the decoder searches the label bits at every phase for the 11-bit pattern 0,1,1,1,1,1,1,1,1,1,0, in the order the bits are received. When the pattern's last bit arrives, `pos_o` becomes 10 and the block enters trial alignment. `locked_o` stays 0.
- R3: `locked_o` rises when the pattern is found again exactly one superframe (32 strobes) later, at slot 10. If that second check misses, the block returns to hunting.
- R4: While locked, one missed check at slot 10 keeps `locked_o` high. A hit after a single miss restores full lock. Two consecutive misses drop `locked_o` to 0.
- R5: While the phase is known, `pos_o` gives the superframe index (0 to 31) of the most recently received slot. Slot 0 is the first pattern bit. The index advances by one per strobe and wraps from 31 to 0.
- R6: The 5-bit count is taken from the concatenation bits of slots 0 to 4, most significant bit first. It is loaded into `count_o` at the slot-4 strobe, if the block is locked when that strobe arrives.
- R7: The 6-bit sequence number is taken from slots 5 to 10, most significant bit first. It is loaded into `seq_o` at the slot-10 strobe, if the block is locked when that strobe arrives.
- R8: The concatenation bits in slots 11 to 31 have no effect on any output.
- R9: While not locked, `count_o` and `seq_o` keep their last values.
- R10: At each count load, `count_err_o` goes to 1 if the new count differs from the previous count plus one (modulo 32), and to 0 otherwise. The first load after lock is acquired always gives 0. Any strobe received while unlocked clears `count_err_o`.
- R11: After reset, every output is 0 and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | One-cycle strobe per 500 µs low-order multiframe |
| label_bit | input | 1 | Extended-label bit carrying the alignment pattern |
| vcat_bit | input | 1 | Serial concatenation bit (count and sequence) |
| count_o | output | 5 | Last latched multiframe count |
| seq_o | output | 6 | Last latched sequence number |
| locked_o | output | 1 | Superframe alignment is locked |
| pos_o | output | 5 | Superframe index of the last received slot |
| count_err_o | output | 1 | Count did not follow the previous one |

## Verification
The hardest state to reach is coast: locked, with exactly one check already missed. In that state the fields are still loaded, and the next check decides between recovering and dropping out. The stimulus reaches it by sending whole superframes whose label pattern is deliberately cleared: one of them, then a good one, then two in a row. Each time it observes `locked_o`, `count_o` and `count_err_o`. A count jump is placed in the second bad superframe, so that the error flag is set just before lock is lost and must then be cleared by the strobes that follow.

// File: rtl/lovc_pkg.sv
package lovc_pkg;

   // Superframe alignment state: search, one confirmation pending, locked, locked with one miss
   typedef enum logic [1:0] {
      AL_HUNT  = 2'd0,
      AL_TRIAL = 2'd1,
      AL_SYNC  = 2'd2,
      AL_COAST = 2'd3
   } align_state_t;

endpackage

// File: rtl/lovc_pattern_det.sv
module lovc_pattern_det #(
   parameter int                   PAT_LEN = 11,
   parameter logic [PAT_LEN-1:0]   PATTERN = 11'b01111111110
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_valid,
   input  logic label_bit,
   output logic hit
);

   if (PAT_LEN < 2) begin : g_bad_len
      $error("lovc_pattern_det: PAT_LEN must be at least 2");
   end

   logic [PAT_LEN-2:0] hist_q;
   logic [PAT_LEN-1:0] window;

   // Oldest received bit lands in the MSB of the window
   assign window = {hist_q, label_bit};
   assign hit    = slot_valid && (window == PATTERN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (slot_valid) begin
         hist_q <= window[PAT_LEN-2:0];
      end
   end

endmodule

// File: rtl/lovc_aligner.sv
module lovc_aligner
   import lovc_pkg::*;
#(
   parameter int SF_SLOTS  = 32,
   parameter int SLOT_W    = 5,
   parameter int CHECK_POS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_valid,
   input  logic              hit,
   output logic              locked,
   output logic [SLOT_W-1:0] in_idx,
   output logic [SLOT_W-1:0] pos_q
);

   localparam logic [SLOT_W-1:0] CHECK_IDX = SLOT_W'(CHECK_POS);
   localparam logic [SLOT_W-1:0] LAST_IDX  = SLOT_W'(SF_SLOTS - 1);

   if (CHECK_POS >= SF_SLOTS) begin : g_bad_check
      $error("lovc_aligner: CHECK_POS must lie inside the superframe");
   end

   align_state_t      st_q, st_d;
   logic [SLOT_W-1:0] pos_d;

   // Index the incoming slot will occupy, given the current phase
   assign in_idx = (pos_q == LAST_IDX) ? '0 : pos_q + SLOT_W'(1);
   assign locked = (st_q == AL_SYNC) || (st_q == AL_COAST);

   always_comb begin
      st_d  = st_q;
      pos_d = pos_q;
      if (slot_valid) begin
         if (st_q == AL_HUNT) begin
            if (hit) begin
               st_d  = AL_TRIAL;
               pos_d = CHECK_IDX;
            end
         end else begin
            pos_d = in_idx;
            if (in_idx == CHECK_IDX) begin
               case (st_q)
                  AL_TRIAL: st_d = hit ? AL_SYNC : AL_HUNT;
                  AL_SYNC:  st_d = hit ? AL_SYNC : AL_COAST;
                  AL_COAST: st_d = hit ? AL_SYNC : AL_HUNT;
                  default:  st_d = AL_HUNT;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= AL_HUNT;
         pos_q <= '0;
      end else begin
         st_q  <= st_d;
         pos_q <= pos_d;
      end
   end

endmodule

// File: rtl/lovc_field_cap.sv
module lovc_field_cap #(
   parameter int SLOT_W = 5,
   parameter int START  = 0,
   parameter int WIDTH  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [SLOT_W-1:0] idx,
   input  logic              data_bit,
   output logic [WIDTH-1:0]  value_q,
   output logic              cap_stb,
   output logic [WIDTH-1:0]  cap_val
);

   if (WIDTH < 2) begin : g_bad_width
      $error("lovc_field_cap: WIDTH must be at least 2");
   end

   logic [WIDTH-2:0]  shift_q;
   logic [SLOT_W-1:0] offset;
   logic              in_field;

   // Offset wraps for slots before START, so one compare bounds both ends
   assign offset   = idx - SLOT_W'(START);
   assign in_field = take && (offset < SLOT_W'(WIDTH));
   assign cap_stb  = take && (offset == SLOT_W'(WIDTH - 1));
   assign cap_val  = {shift_q, data_bit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         value_q <= '0;
      end else begin
         if (in_field) begin
            shift_q <= cap_val[WIDTH-2:0];
         end
         if (cap_stb) begin
            value_q <= cap_val;
         end
      end
   end

endmodule

// File: rtl/lovc_decoder.sv
module lovc_decoder #(
   parameter int                   SF_SLOTS     = 32,
   parameter int                   PAT_LEN      = 11,
   parameter logic [PAT_LEN-1:0]   PATTERN      = 11'b01111111110,
   parameter int                   CNT_START    = 0,
   parameter int                   CNT_W        = 5,
   parameter int                   SEQ_START    = 5,
   parameter int                   SEQ_W        = 6,
   parameter bit                   CONTINUITY_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          slot_valid,
   input  logic                          label_bit,
   input  logic                          vcat_bit,
   output logic [CNT_W-1:0]              count_o,
   output logic [SEQ_W-1:0]              seq_o,
   output logic                          locked_o,
   output logic [$clog2(SF_SLOTS)-1:0]   pos_o,
   output logic                          count_err_o
);

   localparam int SLOT_W    = $clog2(SF_SLOTS);
   localparam int CHECK_POS = PAT_LEN - 1;

   if (SF_SLOTS < 2) begin : g_bad_slots
      $error("lovc_decoder: SF_SLOTS must be at least 2");
   end
   if (PAT_LEN > SF_SLOTS) begin : g_bad_pat
      $error("lovc_decoder: pattern longer than the superframe");
   end
   if (CNT_START + CNT_W > SF_SLOTS || SEQ_START + SEQ_W > SF_SLOTS) begin : g_bad_fields
      $error("lovc_decoder: field exceeds the superframe");
   end
   if (CNT_START < SEQ_START ? (CNT_START + CNT_W > SEQ_START)
                             : (SEQ_START + SEQ_W > CNT_START)) begin : g_overlap
      $error("lovc_decoder: count and sequence fields overlap");
   end

   logic              hit;
   logic              locked;
   logic [SLOT_W-1:0] in_idx;
   logic              take;
   logic              cnt_stb;
   logic [CNT_W-1:0]  cnt_cap;
   logic              seq_stb;
   logic [SEQ_W-1:0]  seq_cap;

   lovc_pattern_det #(
      .PAT_LEN (PAT_LEN),
      .PATTERN (PATTERN)
   ) u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_valid (slot_valid),
      .label_bit  (label_bit),
      .hit        (hit)
   );

   lovc_aligner #(
      .SF_SLOTS  (SF_SLOTS),
      .SLOT_W    (SLOT_W),
      .CHECK_POS (CHECK_POS)
   ) u_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_valid (slot_valid),
      .hit        (hit),
      .locked     (locked),
      .in_idx     (in_idx),
      .pos_q      (pos_o)
   );

   // Field bits are collected only while lock holds at the strobe
   assign take = slot_valid && locked;

   lovc_field_cap #(
      .SLOT_W (SLOT_W),
      .START  (CNT_START),
      .WIDTH  (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .idx      (in_idx),
      .data_bit (vcat_bit),
      .value_q  (count_o),
      .cap_stb  (cnt_stb),
      .cap_val  (cnt_cap)
   );

   lovc_field_cap #(
      .SLOT_W (SLOT_W),
      .START  (SEQ_START),
      .WIDTH  (SEQ_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .idx      (in_idx),
      .data_bit (vcat_bit),
      .value_q  (seq_o),
      .cap_stb  (seq_stb),
      .cap_val  (seq_cap)
   );

   assign locked_o = locked;

   if (CONTINUITY_EN) begin : g_cont
      logic prev_ok_q;
      logic err_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_ok_q <= 1'b0;
            err_q     <= 1'b0;
         end else if (slot_valid && !locked) begin
            prev_ok_q <= 1'b0;
            err_q     <= 1'b0;
         end else if (cnt_stb) begin
            err_q     <= prev_ok_q && (cnt_cap != (count_o + CNT_W'(1)));
            prev_ok_q <= 1'b1;
         end
      end

      assign count_err_o = err_q;
   end else begin : g_no_cont
      assign count_err_o = 1'b0;
   end

   // Sequence capture strobe and value are consumed only inside the capture unit
   logic unused_seq;
   assign unused_seq = ^{seq_stb, seq_cap};

endmodule

// File: rtl/lovc_decoder_chk.sv
module lovc_decoder_chk #(
   parameter int SF_SLOTS  = 32,
   parameter int PAT_LEN   = 11,
   parameter int CNT_START = 0,
   parameter int CNT_W     = 5,
   parameter int SEQ_START = 5,
   parameter int SEQ_W     = 6
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        slot_valid,
   input logic [CNT_W-1:0]            count_o,
   input logic [SEQ_W-1:0]            seq_o,
   input logic                        locked_o,
   input logic [$clog2(SF_SLOTS)-1:0] pos_o,
   input logic                        count_err_o
);

   localparam int SLOT_W = $clog2(SF_SLOTS);
   localparam logic [SLOT_W-1:0] CHECK_IDX = SLOT_W'(PAT_LEN - 1);
   localparam logic [SLOT_W-1:0] CNT_LAST  = SLOT_W'(CNT_START + CNT_W - 1);
   localparam logic [SLOT_W-1:0] SEQ_LAST  = SLOT_W'(SEQ_START + SEQ_W - 1);
   localparam logic [SLOT_W-1:0] LAST_IDX  = SLOT_W'(SF_SLOTS - 1);

   function automatic logic [SLOT_W-1:0] step(input logic [SLOT_W-1:0] p);
      return (p == LAST_IDX) ? '0 : p + SLOT_W'(1);
   endfunction

   assert_quiet_between_slots_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(slot_valid) |-> ($stable(locked_o) && $stable(count_o) && $stable(seq_o)
                              && $stable(pos_o) && $stable(count_err_o)));

   assert_lock_at_check_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> (pos_o == CHECK_IDX));

   assert_pos_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(slot_valid) && $past(locked_o) && locked_o) |-> (pos_o == step($past(pos_o))));

   assert_count_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o != $past(count_o)) |-> ((pos_o == CNT_LAST) && $past(locked_o)));

   assert_seq_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_o != $past(seq_o)) |-> ((pos_o == SEQ_LAST) && $past(locked_o)));

   assert_err_clear_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(slot_valid) && !$past(locked_o)) |-> !count_err_o);

endmodule

bind lovc_decoder lovc_decoder_chk #(
   .SF_SLOTS  (SF_SLOTS),
   .PAT_LEN   (PAT_LEN),
   .CNT_START (CNT_START),
   .CNT_W     (CNT_W),
   .SEQ_START (SEQ_START),
   .SEQ_W     (SEQ_W)
) u_lovc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slot_valid  (slot_valid),
   .count_o     (count_o),
   .seq_o       (seq_o),
   .locked_o    (locked_o),
   .pos_o       (pos_o),
   .count_err_o (count_err_o)
);

// File: tb/test_lovc_decoder.sv
module test_lovc_decoder;

   localparam logic [10:0] PAT = 11'b01111111110;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_valid = 1'b0;
   logic       label_bit = 1'b0;
   logic       vcat_bit = 1'b0;
   logic [4:0] count_o;
   logic [5:0] seq_o;
   logic       locked_o;
   logic [4:0] pos_o;
   logic       count_err_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lovc_decoder i_lovc_decoder (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_valid  (slot_valid),
      .label_bit   (label_bit),
      .vcat_bit    (vcat_bit),
      .count_o     (count_o),
      .seq_o       (seq_o),
      .locked_o    (locked_o),
      .pos_o       (pos_o),
      .count_err_o (count_err_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send_slot(input logic lb, input logic vb);
      @(negedge clk);
      slot_valid = 1'b1;
      label_bit  = lb;
      vcat_bit   = vb;
      @(negedge clk);
      slot_valid = 1'b0;
      label_bit  = ~lb;
      vcat_bit   = ~vb;
      @(negedge clk);
   endtask

   task automatic send_part(input int cnt, input int sq, input bit pat_ok, input bit junk,
                            input int first, input int last);
      logic lb, vb;
      for (int s = first; s <= last; s++) begin
         lb = (pat_ok && s < 11) ? PAT[10-s] : 1'b0;
         if (s < 5)       vb = cnt[4-s];
         else if (s < 11) vb = sq[10-s];
         else             vb = junk ? ((s % 3) != 0) : 1'b0;
         send_slot(lb, vb);
      end
   endtask

   task automatic send_sf(input int cnt, input int sq, input bit pat_ok, input bit junk);
      send_part(cnt, sq, pat_ok, junk, 0, 31);
   endtask

   task automatic t_reset;
      chk("R11", "count_o", count_o, 0);
      chk("R11", "seq_o", seq_o, 0);
      chk("R11", "locked_o", locked_o, 0);
      chk("R11", "pos_o", pos_o, 0);
      chk("R11", "count_err_o", count_err_o, 0);
      // Idle cycles without strobes leave everything untouched
      label_bit = 1'b1; vcat_bit = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1", "pos_o idle", pos_o, 0);
      chk("R1", "locked_o idle", locked_o, 0);
   endtask

   task automatic t_acquire;
      for (int k = 0; k < 7; k++) send_slot(1'b0, 1'b1);
      send_part(1, 9, 1'b1, 1'b0, 0, 10);
      chk("R2", "pos_o after first pattern", pos_o, 10);
      chk("R2", "locked_o after first pattern", locked_o, 0);
      send_part(1, 9, 1'b1, 1'b0, 11, 31);
      chk("R5", "pos_o end of trial superframe", pos_o, 31);
      chk("R9", "count_o before lock", count_o, 0);
      send_sf(2, 9, 1'b1, 1'b0);
      chk("R3", "locked_o after confirmation", locked_o, 1);
      chk("R9", "count_o in confirming superframe", count_o, 0);
      send_sf(3, 9, 1'b1, 1'b0);
      chk("R6", "count_o first load", count_o, 3);
      chk("R7", "seq_o first load", seq_o, 9);
      chk("R10", "count_err_o first load", count_err_o, 0);
   endtask

   task automatic t_fields;
      send_sf(4, 32, 1'b1, 1'b0);
      chk("R7", "seq_o msb only", seq_o, 32);
      chk("R10", "count_err_o in order", count_err_o, 0);
      send_sf(5, 1, 1'b1, 1'b0);
      chk("R7", "seq_o lsb only", seq_o, 1);
      chk("R6", "count_o", count_o, 5);
      send_part(22, 33, 1'b1, 1'b0, 0, 6);
      chk("R5", "pos_o mid superframe", pos_o, 6);
      chk("R6", "count_o after slot 4", count_o, 22);
      chk("R7", "seq_o before slot 10", seq_o, 1);
      chk("R10", "count_err_o jump 5 to 22", count_err_o, 1);
      send_part(22, 33, 1'b1, 1'b0, 7, 31);
      chk("R5", "pos_o wraps to end", pos_o, 31);
      chk("R7", "seq_o after slot 10", seq_o, 33);
   endtask

   task automatic t_ignore;
      send_sf(23, 42, 1'b1, 1'b1);
      chk("R8", "seq_o with junk tail", seq_o, 42);
      chk("R8", "count_o with junk tail", count_o, 23);
      chk("R8", "locked_o with junk tail", locked_o, 1);
      send_sf(24, 42, 1'b1, 1'b1);
      chk("R8", "count_err_o after junk tail", count_err_o, 0);
   endtask

   task automatic t_wrap;
      send_sf(31, 42, 1'b1, 1'b0);
      chk("R10", "count_err_o jump to 31", count_err_o, 1);
      send_sf(0, 42, 1'b1, 1'b0);
      chk("R10", "count_err_o wrap 31 to 0", count_err_o, 0);
      send_sf(0, 42, 1'b1, 1'b0);
      chk("R10", "count_err_o repeated count", count_err_o, 1);
      send_sf(1, 42, 1'b1, 1'b0);
      chk("R10", "count_err_o recovers", count_err_o, 0);
   endtask

   task automatic t_coast;
      send_sf(2, 42, 1'b0, 1'b0);
      chk("R4", "locked_o after one miss", locked_o, 1);
      chk("R4", "count_o loads while coasting", count_o, 2);
      send_sf(3, 42, 1'b1, 1'b0);
      chk("R4", "locked_o after recovery hit", locked_o, 1);
      send_sf(4, 42, 1'b0, 1'b0);
      chk("R4", "locked_o after new single miss", locked_o, 1);
      send_part(9, 42, 1'b0, 1'b0, 0, 4);
      chk("R10", "count_err_o set before loss", count_err_o, 1);
      send_part(9, 42, 1'b0, 1'b0, 5, 31);
      chk("R4", "locked_o after two misses", locked_o, 0);
      chk("R6", "count_o loaded in second miss", count_o, 9);
      chk("R10", "count_err_o cleared while unlocked", count_err_o, 0);
   endtask

   task automatic t_relock;
      send_sf(12, 50, 1'b1, 1'b0);
      chk("R9", "count_o held while hunting", count_o, 9);
      chk("R9", "seq_o held while hunting", seq_o, 42);
      chk("R3", "locked_o after first hit", locked_o, 0);
      send_sf(13, 50, 1'b0, 1'b0);
      chk("R3", "locked_o after trial miss", locked_o, 0);
      send_sf(14, 50, 1'b1, 1'b0);
      chk("R3", "locked_o restarted trial", locked_o, 0);
      chk("R2", "pos_o phase after restart", pos_o, 31);
      send_sf(15, 50, 1'b1, 1'b0);
      chk("R3", "locked_o relocked", locked_o, 1);
      chk("R9", "count_o still held", count_o, 9);
      send_sf(20, 51, 1'b1, 1'b0);
      chk("R6", "count_o after relock", count_o, 20);
      chk("R7", "seq_o after relock", seq_o, 51);
      chk("R10", "count_err_o first load after relock", count_err_o, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_acquire();
      t_fields();
      t_ignore();
      t_wrap();
      t_coast();
      t_relock();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule